// File: doc/BRIEF.md
# Four-Lane Byte Interleaving Multiplexer

This block gathers four byte lanes, each with its own frame marker and parity bit, and merges them into one byte stream that runs four times faster than the lane word rate. The same stream also leaves as a serial bit sequence with the most significant bit first. Each group of four input words is buffered and then sent out in one of two orders. In rotating order the lanes take turns byte by byte. In grouped order all four bytes of lane A leave first, then those of lane B, then C, then D. A parity check runs on every lane alongside the data and flags mismatches one cycle after the word is captured.

The whole block runs on a single bit-rate clock. A 7-bit position counter splits each 128-cycle group period into four word periods of 32 cycles. Each word period holds four byte slots, and each byte slot holds eight bit positions. The block raises `word_take` in the cycle whose rising edge captures the lane inputs. Lane A sits in the lowest byte of `lane_data`.

Top module: `byte_ilv_mux`

## Requirements
- R1: `word_take` is high exactly when the position counter is a multiple of 32. That is the first cycle after reset release and every 32nd cycle after it. The lane inputs are captured on the rising edge that ends such a cycle, and that capture is word number (position / 32) of the current group.
- R2: In rotating order (`mode_grouped` = 0), output byte k of a group (k = 0..15) is lane k%4 of word k/4.
- R3: In grouped order (`mode_grouped` = 1), output byte k of a group is lane k/4 of word k%4.
- R4: The four words captured during group period g leave during group period g+1. Byte k is held on `out_byte` for positions 8k to 8k+7 of that period.
- R5: At bit position b (0..7) of a byte slot, `out_ser` equals bit 7-b of the byte on `out_byte`, so bit 7 leaves first.
- R6: `out_fp` is high for the whole byte slot that carries the lane A byte of a word in which any lane frame pulse was high. It is low in every other slot.
- R7: `par_err[i]` is high for exactly one cycle, the cycle after the capture edge, when `lane_par[i]` differs from the XOR of lane i's 8 data bits and its frame pulse. It is low at all other times.
- R8: The mode value present in position 127 of a group period sets the order of the whole next output group. Changes at any other position have no effect on the group being sent.
- R9: Synchronous reset clears the counter, both buffers and the error flags. During reset, and for the first output group after release, `out_byte`, `out_fp`, `out_ser` and `par_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_grouped | input | 1 | 0 = rotating order, 1 = grouped order |
| lane_data | input | 32 | Four lane bytes, lane i in bits 8i+7..8i |
| lane_fp | input | 4 | Frame pulse per lane |
| lane_par | input | 4 | Even parity bit per lane |
| word_take | output | 1 | High in the cycle whose edge captures the lanes |
| par_err | output | 4 | Per-lane parity mismatch, one cycle late |
| out_byte | output | 8 | Interleaved byte stream, one byte per 8 cycles |
| out_fp | output | 1 | Output frame marker, one byte slot long |
| out_ser | output | 1 | Serial stream, MSB first |

## Verification
The parity flag comes one cycle after the capture edge, so the bench reads `par_err` at the falling edge of position 1 of each word period and expects zero at every other position. Output bytes come one full group period after capture. The bench pushes the sixteen expected items of a group into a queue at position 127, using the mode present then. A monitor pops one item at position 0 of each byte slot. It checks the byte and frame marker across all eight positions of the slot and checks the serial bit at each position. All sampling happens at falling edges, and the bench keeps its own count of positions from the release of reset.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic {
        ORD_ROTATE  = 1'b0,
        ORD_GROUPED = 1'b1
    } order_e;
endpackage

// File: rtl/ilv_timing.sv
module ilv_timing #(
    parameter int N = 4,
    parameter int W = 8,
    localparam int NW = $clog2(N),
    localparam int BW = $clog2(W),
    localparam int CW = 2 * NW + BW
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] pos,
    output logic [NW-1:0] word_idx,
    output logic [2*NW-1:0] slot_k,
    output logic [BW-1:0] bit_idx,
    output logic          take,
    output logic          grp_end
);
    typedef struct packed {
        logic [CW-1:0] pos;
    } tim_t;

    tim_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.pos = s_q.pos + 1'b1;
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign pos      = s_q.pos;
    assign word_idx = s_q.pos[CW-1:CW-NW];
    assign slot_k   = s_q.pos[CW-1:BW];
    assign bit_idx  = s_q.pos[BW-1:0];
    assign take     = (s_q.pos[NW+BW-1:0] == '0);
    assign grp_end  = &s_q.pos;
endmodule

// File: rtl/ilv_parity.sv
module ilv_parity #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           take,
    input  logic [N*W-1:0] lane_data,
    input  logic [N-1:0]   lane_fp,
    input  logic [N-1:0]   lane_par,
    output logic [N-1:0]   err
);
    typedef struct packed {
        logic [N-1:0] err;
    } par_t;

    par_t         s_q, s_d;
    logic [N-1:0] miss;

    for (genvar l = 0; l < N; l++) begin : g_lane
        assign miss[l] = (^{lane_fp[l], lane_data[l*W +: W]}) ^ lane_par[l];
    end

    always_comb begin
        s_d     = s_q;
        s_d.err = take ? miss : '0;
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign err = s_q.err;
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8,
    localparam int NW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            grp_end,
    input  logic            mode_sel,
    input  logic [NW-1:0]   word_idx,
    input  logic [2*NW-1:0] slot_k,
    input  logic [N*W-1:0]  lane_data,
    input  logic [N-1:0]    lane_fp,
    output logic [W-1:0]    sel_byte,
    output logic            sel_fp,
    output logic            grp_mode
);
    typedef struct packed {
        logic [N-1:0][N-1:0][W-1:0] wr;
        logic [N-1:0]               wr_fp;
        logic [N-1:0][N-1:0][W-1:0] rd;
        logic [N-1:0]               rd_fp;
        order_e                     mode;
    } bank_t;

    bank_t         s_q, s_d;
    logic [NW-1:0] wsel, lsel;

    always_comb begin
        s_d = s_q;
        if (take) begin
            for (int l = 0; l < N; l++) begin
                s_d.wr[word_idx][l] = lane_data[l*W +: W];
            end
            s_d.wr_fp[word_idx] = |lane_fp;
        end
        if (grp_end) begin
            s_d.rd    = s_q.wr;
            s_d.rd_fp = s_q.wr_fp;
            s_d.mode  = order_e'(mode_sel);
        end
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    always_comb begin
        if (s_q.mode == ORD_GROUPED) begin
            wsel = slot_k[NW-1:0];
            lsel = slot_k[2*NW-1:NW];
        end else begin
            wsel = slot_k[2*NW-1:NW];
            lsel = slot_k[NW-1:0];
        end
    end

    assign sel_byte = s_q.rd[wsel][lsel];
    assign sel_fp   = s_q.rd_fp[wsel] && (lsel == '0);
    assign grp_mode = (s_q.mode == ORD_GROUPED);
endmodule

// File: rtl/byte_ilv_mux.sv
module byte_ilv_mux #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_grouped,
    input  logic [N*W-1:0] lane_data,
    input  logic [N-1:0]   lane_fp,
    input  logic [N-1:0]   lane_par,
    output logic           word_take,
    output logic [N-1:0]   par_err,
    output logic [W-1:0]   out_byte,
    output logic           out_fp,
    output logic           out_ser
);
    localparam int NW = $clog2(N);
    localparam int BW = $clog2(W);
    localparam int CW = 2 * NW + BW;
    localparam logic [BW-1:0] MSB_IDX = BW'(W - 1);

    logic [CW-1:0]   pos;
    logic [NW-1:0]   word_idx;
    logic [2*NW-1:0] slot_k;
    logic [BW-1:0]   bit_idx;
    logic            take;
    logic            grp_end;
    logic [W-1:0]    sel_byte;
    logic            sel_fp;
    logic            grp_mode;

    ilv_timing #(.N(N), .W(W)) u_tim (
        .clk      (clk),
        .rst      (rst),
        .pos      (pos),
        .word_idx (word_idx),
        .slot_k   (slot_k),
        .bit_idx  (bit_idx),
        .take     (take),
        .grp_end  (grp_end)
    );

    ilv_parity #(.N(N), .W(W)) u_par (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .lane_data (lane_data),
        .lane_fp   (lane_fp),
        .lane_par  (lane_par),
        .err       (par_err)
    );

    ilv_bank #(.N(N), .W(W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .grp_end   (grp_end),
        .mode_sel  (mode_grouped),
        .word_idx  (word_idx),
        .slot_k    (slot_k),
        .lane_data (lane_data),
        .lane_fp   (lane_fp),
        .sel_byte  (sel_byte),
        .sel_fp    (sel_fp),
        .grp_mode  (grp_mode)
    );

    assign word_take = take;
    assign out_byte  = sel_byte;
    assign out_fp    = sel_fp;
    assign out_ser   = sel_byte[MSB_IDX - bit_idx];
endmodule

// File: rtl/ilv_chk.sv
module ilv_chk #(
    parameter int N = 4,
    parameter int W = 8,
    localparam int NW = $clog2(N),
    localparam int BW = $clog2(W),
    localparam int CW = 2 * NW + BW
) (
    input logic          clk,
    input logic          rst,
    input logic          word_take,
    input logic [N-1:0]  par_err,
    input logic [W-1:0]  out_byte,
    input logic          out_fp,
    input logic [CW-1:0] pos,
    input logic          grp_mode
);
    // R1
    take_gap_chk: assert property (@(posedge clk) disable iff (rst)
        word_take |=> !word_take);

    // R7
    err_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (|par_err) |-> $past(word_take));

    // R4
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pos[BW-1:0] != '0) |-> $stable(out_byte));

    // R6
    fp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pos[BW-1:0] != '0) |-> $stable(out_fp));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pos != '0) |-> $stable(grp_mode));

    // R9
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_byte == '0 && par_err == '0 && !out_fp));
endmodule

bind byte_ilv_mux ilv_chk #(.N(N), .W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .word_take (word_take),
    .par_err   (par_err),
    .out_byte  (out_byte),
    .out_fp    (out_fp),
    .pos       (pos),
    .grp_mode  (grp_mode)
);

// File: tb/tb_byte_ilv_mux.sv
module tb_byte_ilv_mux;
    localparam int GROUPS = 9;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_grouped;
    logic [31:0] lane_data;
    logic [3:0]  lane_fp;
    logic [3:0]  lane_par;
    logic        word_take;
    logic [3:0]  par_err;
    logic [7:0]  out_byte;
    logic        out_fp;
    logic        out_ser;

    typedef struct {
        logic [7:0] b;
        logic       f;
        string      req;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] gd[4][4];
    logic       gf[4];
    logic [3:0] bad_mask;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    always #5 clk = ~clk;

    byte_ilv_mux dut (
        .clk          (clk),
        .rst          (rst),
        .mode_grouped (mode_grouped),
        .lane_data    (lane_data),
        .lane_fp      (lane_fp),
        .lane_par     (lane_par),
        .word_take    (word_take),
        .par_err      (par_err),
        .out_byte     (out_byte),
        .out_fp       (out_fp),
        .out_ser      (out_ser)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_mode(input logic m, inout bit touched);
        if (mode_grouped != m) touched = 1;
        mode_grouped = m;
    endtask

    // driver
    initial begin
        bit touched;
        rst = 1'b1;
        mode_grouped = 1'b0;
        lane_data = '0;
        lane_fp = '0;
        lane_par = '0;
        bad_mask = '0;
        // R9: first output group after release carries zeros
        for (int k = 0; k < 16; k++) sb_q.push_back('{b: 8'h00, f: 1'b0, req: "R9"});
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_byte == 8'h00, "R9", out_byte, 0);
        chk(out_fp == 1'b0, "R9", out_fp, 0);
        chk(out_ser == 1'b0, "R9", out_ser, 0);
        chk(par_err == 4'h0, "R9", par_err, 0);
        rst = 1'b0;
        touched = 0;
        for (int t = 0; t < GROUPS * 128; t++) begin
            int ph;
            int g;
            if (t > 0) @(negedge clk);
            ph = t % 128;
            g  = t / 128;
            if (ph == 0) touched = 0;
            // R8: mode schedule, including changes in the middle of a group
            case (g)
                1: if (ph == 40) set_mode(1'b1, touched);
                2: begin
                    if (ph == 10) set_mode(1'b0, touched);
                    if (ph == 90) set_mode(1'b1, touched);
                end
                3: if (ph == 127) set_mode(1'b0, touched);
                4: if (ph == 0) set_mode(1'b1, touched);
                6: begin
                    if (ph == 60) set_mode(1'b0, touched);
                    if (ph == 100) set_mode(1'b1, touched);
                    if (ph == 120) set_mode(1'b0, touched);
                end
                7: if (ph == 5) set_mode(1'b1, touched);
                default: ;
            endcase
            if (ph % 32 == 0) begin
                int         w;
                logic [3:0] fpv;
                logic [3:0] badv;
                w = ph / 32;
                fpv = '0;
                if (w == 0) fpv[g % 4] = 1'b1;
                if (w == 2 && (g % 2) == 1) fpv = 4'b0011;
                badv = (w == 1) ? 4'(g % 16) : ((w == 3 && g == 2) ? 4'hF : 4'h0);
                for (int l = 0; l < 4; l++) begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    lane_data[l*8 +: 8] = d;
                    gd[w][l] = d;
                    lane_par[l] = (^{fpv[l], d}) ^ badv[l];
                end
                lane_fp = fpv;
                gf[w] = |fpv;
                bad_mask = badv;
            end
            if (ph == 127) begin
                for (int k = 0; k < 16; k++) begin
                    int    w;
                    int    l;
                    string rq;
                    if (mode_grouped) begin
                        w = k % 4;
                        l = k / 4;
                    end else begin
                        w = k / 4;
                        l = k % 4;
                    end
                    rq = touched ? "R8" : (mode_grouped ? "R3" : "R2");
                    sb_q.push_back('{b: gd[w][l], f: gf[w] && (l == 0), req: rq});
                end
            end
        end
    end

    // monitor
    initial begin
        item_t cur;
        cur = '{b: 8'h00, f: 1'b0, req: "R9"};
        wait (rst == 1'b0);
        for (int t = 0; t < GROUPS * 128; t++) begin
            int ph;
            if (t > 0) @(negedge clk);
            ph = t % 128;
            // R1: capture strobe every 32 positions
            chk(word_take == (ph % 32 == 0), "R1", word_take, (ph % 32 == 0));
            // R7: parity flag one cycle after capture only
            if (ph % 32 == 1) chk(par_err == bad_mask, "R7", par_err, bad_mask);
            else chk(par_err == 4'h0, "R7", par_err, 0);
            if (ph % 8 == 0) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R4", 0, 1);
                end else begin
                    cur = sb_q.pop_front();
                end
                chk(out_byte == cur.b, cur.req, out_byte, cur.b);
                chk(out_fp == cur.f, "R6", out_fp, cur.f);
            end else begin
                chk(out_byte == cur.b, "R4", out_byte, cur.b);
                chk(out_fp == cur.f, "R6", out_fp, cur.f);
            end
            chk(out_ser == cur.b[7 - (ph % 8)], "R5", out_ser, cur.b[7 - (ph % 8)]);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule